// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Edge Select

This block is an up-counter paired with one register that serves either as a compare value or as a capture store. In compare mode the counter either runs freely and wraps, or clears and restarts whenever it reaches the compare value. Either way, a match raises a single-cycle interrupt pulse. In capture mode, an edge on one of two asynchronous pins copies the running count into the register and raises the same pulse.

Capture has two trigger sources. The primary pin captures on the edge opposite to the one its 2-bit edge code selects, and captures nothing when the code selects both edges. The secondary pin captures on exactly the edge its own code selects. Both pins are synchronized inside the block before their edges are detected. The counter width is a parameter and defaults to 16 bits.

Top module: `tmr_capcmp`

## Requirements
- R1: While rst_n is low, count, reg_val, irq and ovf are all zero.
- R2: With cnt_en high, count rises by one on each clock edge. With cnt_en low, count holds. When count steps from all-ones to zero, ovf is high for exactly the following cycle.
- R3: Free-running compare (cap_mode=0, clr_on_match=0): the clock edge that steps count out of the value equal to reg_val also sets irq for one cycle, and count keeps going. When reg_val is zero, only a step out of zero that comes after an overflow raises irq; the first step out of zero after reset does not.
- R4: Clear-on-match compare (cap_mode=0, clr_on_match=1): a counting edge taken while count equals reg_val loads zero into count and sets irq for one cycle. For a nonzero reg_val the count therefore repeats with period reg_val+1.
- R5: In clear-on-match mode, if reg_val is written below the current count, count runs on to all-ones, wraps with an ovf pulse, and clears only on reaching reg_val after the wrap.
- R6: Each pin passes through two synchronizing flops and one history flop. A pin change first sampled at clock edge k takes effect at edge k+2. At that edge reg_val takes the count held just before edge k+2, and irq is high for the one cycle that follows.
- R7: Primary source (cap_mode=1, cap_src=1): esel_a=00 captures on a rising edge of pin_a, esel_a=01 captures on a falling edge, and esel_a=11 or 10 never captures.
- R8: Secondary source (cap_mode=1, cap_src=0): esel_b=00 captures on a falling edge of pin_b, 01 on a rising edge, 11 on either edge, and 10 never captures.
- R9: When a capture and a register write fall on the same clock edge, the captured count is stored and the write is lost.
- R10: With no capture on that edge, wr_en loads wr_data into reg_val at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| pin_a | input | 1 | Primary capture pin (asynchronous) |
| pin_b | input | 1 | Secondary capture pin (asynchronous) |
| cap_mode | input | 1 | 1 = capture mode, 0 = compare mode |
| cap_src | input | 1 | Capture source: 1 = primary pin, 0 = secondary pin |
| clr_on_match | input | 1 | In compare mode, clear the counter on a match |
| esel_a | input | 2 | Edge code for pin_a |
| esel_b | input | 2 | Edge code for pin_b |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | W | Register write data |
| count | output | W | Counter value |
| reg_val | output | W | Compare/capture register |
| irq | output | 1 | One-cycle match/capture pulse |
| ovf | output | 1 | One-cycle overflow pulse |

## Verification
Count, ovf and the compare interrupt all change at the clock edge that performs the step, so after each counting edge they are compared with the arithmetic prediction for step number n. A capture arrives at the third clock edge after the pin was driven. Its stored value must be the count seen at the drive point plus two, and the bench samples at exactly that falling edge and again one cycle later to confirm irq has dropped. Inputs change only on falling edges, which keeps every comparison one clean half-period away from the edge that produced the value.

// File: rtl/tmr_capcmp.sv
module tmr_capcmp #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         pin_a,
  input  logic         pin_b,
  input  logic         cap_mode,
  input  logic         cap_src,
  input  logic         clr_on_match,
  input  logic [1:0]   esel_a,
  input  logic [1:0]   esel_b,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] count,
  output logic [W-1:0] reg_val,
  output logic         irq,
  output logic         ovf
);

  // [0],[1] synchronizer, [2] history
  logic [2:0] a_sh, b_sh;
  logic       zero_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_sh <= '0;
      b_sh <= '0;
    end else begin
      a_sh <= {a_sh[1:0], pin_a};
      b_sh <= {b_sh[1:0], pin_b};
    end

  wire rise_a = a_sh[1] & ~a_sh[2];
  wire fall_a = ~a_sh[1] & a_sh[2];
  wire rise_b = b_sh[1] & ~b_sh[2];
  wire fall_b = ~b_sh[1] & b_sh[2];

  wire trig_a = (esel_a == 2'b00 & rise_a) | (esel_a == 2'b01 & fall_a);
  wire trig_b = (esel_b == 2'b00 & fall_b) | (esel_b == 2'b01 & rise_b) |
                (esel_b == 2'b11 & (rise_b | fall_b));
  wire trig   = cap_mode & (cap_src ? trig_a : trig_b);

  wire hit     = (count == reg_val);
  wire clr_hit = ~cap_mode & clr_on_match & hit;
  wire cmp_irq = ~cap_mode & cnt_en & hit &
                 (clr_on_match | (reg_val != '0) | zero_ok);
  wire wrap    = cnt_en & (count == {W{1'b1}}) & ~clr_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      count   <= '0;
      reg_val <= '0;
      irq     <= 1'b0;
      ovf     <= 1'b0;
      zero_ok <= 1'b0;
    end else begin
      if (cnt_en) count <= clr_hit ? '0 : count + 1'b1;
      if (trig)       reg_val <= count;
      else if (wr_en) reg_val <= wr_data;
      irq     <= trig | cmp_irq;
      ovf     <= wrap;
      zero_ok <= zero_ok | wrap;
    end

endmodule

// File: rtl/tmr_capcmp_chk.sv
module tmr_capcmp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         cap_mode,
  input logic         clr_on_match,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic [W-1:0] count,
  input logic [W-1:0] reg_val,
  input logic         irq,
  input logic         ovf
);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> count == $past(count));

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !(!cap_mode && clr_on_match && count == reg_val)
    |=> count == W'($past(count) + 1'b1));

  a_r2_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> count == '0 && $past(count) == {W{1'b1}});

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en && !cap_mode && clr_on_match && count == reg_val
    |=> count == '0 && irq);

  a_r10_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !cap_mode |=> reg_val == $past(wr_data));

  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en && !cap_mode |=> $stable(reg_val));

endmodule

bind tmr_capcmp tmr_capcmp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_mode(cap_mode),
  .clr_on_match(clr_on_match), .wr_en(wr_en), .wr_data(wr_data),
  .count(count), .reg_val(reg_val), .irq(irq), .ovf(ovf)
);

// File: tb/tmr_capcmp_test.sv
module tmr_capcmp_test;
  localparam int W  = 8;
  localparam int MX = 1 << W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cnt_en = 0, pin_a = 0, pin_b = 0, cap_mode = 0, cap_src = 0, clr_on_match = 0;
  logic [1:0] esel_a = 0, esel_b = 0;
  logic wr_en = 0;
  logic [W-1:0] wr_data = 0;
  logic [W-1:0] count, reg_val;
  logic irq, ovf;

  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  tmr_capcmp #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .pin_a(pin_a), .pin_b(pin_b),
    .cap_mode(cap_mode), .cap_src(cap_src), .clr_on_match(clr_on_match),
    .esel_a(esel_a), .esel_b(esel_b), .wr_en(wr_en), .wr_data(wr_data),
    .count(count), .reg_val(reg_val), .irq(irq), .ovf(ovf)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", r, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cnt_en = 0; wr_en = 0; cap_mode = 0; clr_on_match = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_reg(input int v);
    wr_en = 1; wr_data = W'(v);
    @(negedge clk);
    wr_en = 0;
  endtask

  int cmp_list[4] = '{0, 1, 7, 200};

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    @(negedge clk);
    chk("R1 count", count, 0);
    chk("R1 reg", reg_val, 0);
    chk("R1 irq", irq, 0);
    chk("R1 ovf", ovf, 0);

    // R2, R3 free-running compare sweep
    foreach (cmp_list[i]) begin
      do_reset();
      write_reg(cmp_list[i]);
      chk("R10 write", reg_val, cmp_list[i]);
      cnt_en = 1;
      for (int n = 1; n <= 300; n++) begin
        @(negedge clk);
        chk("R2 count", count, n % MX);
        chk("R2 ovf", ovf, int'(n % MX == 0));
        chk("R3 irq", irq, int'(((n - 1) % MX == cmp_list[i]) && !(cmp_list[i] == 0 && n == 1)));
      end
      cnt_en = 0;
      repeat (3) @(negedge clk);
      chk("R2 hold", count, 300 % MX);
    end

    // R4 clear-on-match sweep
    for (int c = 1; c <= 7; c++) begin
      do_reset();
      write_reg(c);
      clr_on_match = 1; cnt_en = 1;
      for (int n = 1; n <= 40; n++) begin
        @(negedge clk);
        chk("R4 count", count, n % (c + 1));
        chk("R4 irq", irq, int'(n % (c + 1) == 0));
        chk("R4 ovf", ovf, 0);
      end
    end

    // R5 compare written below count
    do_reset();
    write_reg(200);
    clr_on_match = 1; cnt_en = 1;
    repeat (30) @(negedge clk);
    cnt_en = 0;
    chk("R5 start", count, 30);
    write_reg(10);
    cnt_en = 1;
    for (int n = 1; n <= 237; n++) begin
      @(negedge clk);
      chk("R5 count", count, (n < 237) ? (30 + n) % MX : 0);
      chk("R5 irq", irq, int'(n == 237));
      chk("R5 ovf", ovf, int'(n == 226));
    end

    // R6..R9 capture sweep
    for (int conf = 0; conf < 2; conf++)
      for (int src = 0; src < 2; src++)
        for (int code = 0; code < 4; code++)
          for (int rising = 0; rising < 2; rising++) begin
            bit cap;
            int c0, fill;
            do_reset();
            cap_mode = 1; cap_src = src[0];
            esel_a = code[1:0]; esel_b = code[1:0];
            pin_a = rising ? 1'b0 : 1'b1;
            pin_b = pin_a;
            cnt_en = 1;
            repeat (4) @(negedge clk);
            write_reg(8'hA5);
            repeat (2) @(negedge clk);
            chk("R6 idle irq", irq, 0);
            if (src == 1) cap = (code == 0 && rising == 1) || (code == 1 && rising == 0);
            else cap = (code == 0 && rising == 0) || (code == 1 && rising == 1) || code == 3;
            fill = conf ? 8'h3C : 8'hA5;
            c0 = count;
            pin_a = ~pin_a; pin_b = ~pin_b;
            repeat (2) @(negedge clk);
            if (conf) begin
              wr_en = 1; wr_data = 8'h3C;
            end
            @(negedge clk);
            wr_en = 0;
            if (src == 1) begin
              chk("R7 reg", reg_val, cap ? (c0 + 2) % MX : fill);
              chk("R7 irq", irq, int'(cap));
            end else begin
              chk("R8 reg", reg_val, cap ? (c0 + 2) % MX : fill);
              chk("R8 irq", irq, int'(cap));
            end
            if (conf) chk("R9 capture wins", reg_val, cap ? (c0 + 2) % MX : 8'h3C);
            @(negedge clk);
            chk("R6 irq one cycle", irq, 0);
          end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule